// File: doc/BRIEF.md
# Configurable-Width External Strobe Generator

This block sits between a 32-bit processor core and its external memory pins. It drives two groups of four active-low strobe pins, one group per memory space, and a single strobe for the I/O space. Each memory space has a control register with a two-bit physical-width field that says whether the memory behind that space is 8, 16 or 32 bits wide. The field decides the role of every pin in the group. In a 32-bit space all four pins are byte-lane enables. In narrower spaces the upper pins become the lowest extra address lines and carry the byte address below the word address.

A request from the core names the space, the word address, the access size, the byte offset and the direction. It is accepted only while the block is idle. When the access is wider than the memory, the block splits it into two or four external cycles in ascending address order and steps the extra address lines from one cycle to the next. A one-cycle done pulse follows the last sub-cycle. An address-role pin carries the current low address bits on every external access, whichever space is being accessed, and keeps that value between accesses.

Top module: `xstrobe_gen`

## Requirements
- R1: The width field of each memory-space register is at bits 17:16 of the written and read-back word. The codes are 00 for 8-bit memory, 01 for 16-bit memory and 11 for 32-bit memory. The other bits read as zero.
- R2: Reset loads the width field of both spaces from the strap input: 01 when the strap is high, 11 when it is low. After reset the block is idle, done is low and the address value is 00.
- R3: A write of the reserved code 10 leaves the field of the selected space at its previous value.
- R4: In a 32-bit space, strobe pin p (bits 4s+p of `strb_n`) enables byte lane p. A byte, halfword or word access takes one cycle and drives low the pins of the lanes it covers.
- R5: In a 16-bit space, pin 3 carries byte-address bit 1, pins 1:0 enable the low and high byte of the halfword, and pin 2 stays high. A word access takes two cycles, address bit 1 = 0 first and then 1.
- R6: In an 8-bit space, pin 3 carries byte-address bit 1, pin 2 carries byte-address bit 0, pin 0 is the only enable and pin 1 stays high. A word access takes four cycles at byte addresses 0,1,2,3. A halfword access takes two cycles.
- R7: An address-role pin carries the current sub-cycle's low address bits during accesses to any space, including the I/O space, and holds the last value while the block is idle.
- R8: An enable-role pin is low only during a sub-cycle of an access to its own space. `io_strb_n` is low only during an I/O access (space codes 2 and 3). Memory spaces use codes 0 and 1.
- R9: `busy` is high for exactly the sub-cycles of a transfer. `done` is high for one cycle, in the cycle that follows the last sub-cycle.
- R10: A request presented while busy is ignored. The word address, direction and sequence of the transfer in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_narrow | input | 1 | Strap; high selects 16-bit width at reset, low selects 32-bit |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | Memory space selected for write and read-back |
| cfg_wdata | input | 32 | Control register write data; only bits 17:16 are used |
| cfg_rdata | output | 32 | Read-back of the selected control register |
| req_valid | input | 1 | Transfer request |
| req_space | input | 2 | 0, 1: memory spaces; 2, 3: I/O space |
| req_addr | input | 24 | Word address |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_off | input | 2 | Byte offset within the word for byte and halfword accesses |
| req_write | input | 1 | 1 for a write, 0 for a read |
| busy | output | 1 | A transfer is in its sub-cycles |
| done | output | 1 | One-cycle pulse after the last sub-cycle |
| ext_addr | output | 24 | Word address of the current or last transfer |
| ext_wr | output | 1 | Direction of the current or last transfer |
| strb_n | output | 8 | Strobe pins, four per memory space, space s at bits 4s+3:4s |
| io_strb_n | output | 1 | Active-low I/O space strobe |

## Verification
A request is accepted at the rising edge where it is seen while the block is idle. Sub-cycle k of the transfer is visible from edge k after acceptance, so the bench checks the pins, `busy` and the word address at the falling edge following each of those edges. The done pulse appears one edge after the last sub-cycle and is checked at that falling edge, and again one cycle later to confirm it lasted a single cycle. Register writes take effect at the edge that samples them, and the read-back is combinational, so the bench reads it back at the next falling edge and also checks the idle pin values there.

// File: rtl/xstrobe_pkg.sv
package xstrobe_pkg;

    localparam int PINS   = 4;
    localparam int WF_LSB = 16;

    typedef enum logic [1:0] {
        W8   = 2'b00,
        W16  = 2'b01,
        WRSV = 2'b10,
        W32  = 2'b11
    } mwidth_e;

    typedef struct packed {
        logic [1:0] space;
        mwidth_e    w;
        logic [2:0] sb;
        logic       wr;
    } xfer_t;

    function automatic logic [2:0] width_bytes(input mwidth_e w);
        case (w)
            W8:      return 3'd1;
            W16:     return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] align_off(input logic [1:0] off, input logic [2:0] sb);
        if (sb == 3'd4)      return 2'b00;
        else if (sb == 3'd2) return {off[1], 1'b0};
        else                 return off;
    endfunction

    // active-high lane enables of the accessed space for one sub-cycle
    function automatic logic [PINS-1:0] lane_en(input mwidth_e w, input logic [2:0] sb,
                                                input logic [1:0] lo);
        case (w)
            W32: begin
                if (sb == 3'd4)      return 4'b1111;
                else if (sb == 3'd2) return lo[1] ? 4'b1100 : 4'b0011;
                else                 return 4'b0001 << lo;
            end
            W16: begin
                if (sb == 3'd1)      return lo[0] ? 4'b0010 : 4'b0001;
                else                 return 4'b0011;
            end
            default:                 return 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/xs_cfg.sv
module xs_cfg
    import xstrobe_pkg::*;
#(
    parameter int NSPACE = 2,
    localparam int SEL_W = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    strap_narrow,
    input  logic                    we,
    input  logic [SEL_W-1:0]        sel,
    input  logic [1:0]              code,
    output logic [NSPACE-1:0][1:0]  wmem
);
    for (genvar i = 0; i < NSPACE; i++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst)
                wmem[i] <= strap_narrow ? W16 : W32;
            else if (we && sel == SEL_W'(i) && code != WRSV)
                wmem[i] <= code;
        end
    end
endmodule

// File: rtl/xs_seq.sv
module xs_seq
    import xstrobe_pkg::*;
#(
    parameter int NSPACE = 2,
    parameter int ADDR_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [1:0]              req_space,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [1:0]              req_off,
    input  logic                    req_write,
    input  logic [NSPACE-1:0][1:0]  wmem,
    output logic                    busy,
    output logic                    done,
    output xfer_t                   cur,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [1:0]              lo_q
);
    mwidth_e    w_req;
    logic [2:0] sb_req;
    logic [2:0] wb_req;
    logic [1:0] last_req;
    logic [1:0] cnt_q, last_q, step_q;

    always_comb begin
        w_req = W32;
        for (int i = 0; i < NSPACE; i++)
            if (req_space == 2'(i)) w_req = mwidth_e'(wmem[i]);
        sb_req = size_bytes(req_size);
        wb_req = width_bytes(w_req);
        if (sb_req > wb_req)
            last_req = (sb_req == 3'd4 && wb_req == 3'd1) ? 2'd3 : 2'd1;
        else
            last_req = 2'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cur    <= '0;
            addr_q <= '0;
            lo_q   <= 2'b00;
            cnt_q  <= 2'd0;
            last_q <= 2'd0;
            step_q <= 2'd0;
        end else begin
            done <= 1'b0;
            if (!busy && req_valid) begin
                busy   <= 1'b1;
                cur    <= '{space: req_space, w: w_req, sb: sb_req, wr: req_write};
                addr_q <= req_addr;
                lo_q   <= align_off(req_off, sb_req);
                cnt_q  <= 2'd0;
                last_q <= last_req;
                step_q <= wb_req[1:0];
            end else if (busy) begin
                if (cnt_q == last_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 2'd1;
                    lo_q  <= lo_q + step_q;
                end
            end
        end
    end
endmodule

// File: rtl/xs_pinmux.sv
module xs_pinmux
    import xstrobe_pkg::*;
(
    input  mwidth_e          cfg_w,
    input  logic             sel_here,
    input  logic [PINS-1:0]  en,
    input  logic [1:0]       lo,
    output logic [PINS-1:0]  pins_n
);
    always_comb begin
        pins_n = sel_here ? ~en : {PINS{1'b1}};
        if (cfg_w != W32) pins_n[PINS-1] = lo[1];
        if (cfg_w == W8)  pins_n[PINS-2] = lo[0];
    end
endmodule

// File: rtl/xstrobe_gen.sv
module xstrobe_gen
    import xstrobe_pkg::*;
#(
    parameter int NSPACE = 2,
    parameter int ADDR_W = 24,
    localparam int SEL_W = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    strap_narrow,
    input  logic                    cfg_we,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic                    req_valid,
    input  logic [1:0]              req_space,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [1:0]              req_off,
    input  logic                    req_write,
    output logic                    busy,
    output logic                    done,
    output logic [ADDR_W-1:0]       ext_addr,
    output logic                    ext_wr,
    output logic [NSPACE*PINS-1:0]  strb_n,
    output logic                    io_strb_n
);
    logic [NSPACE-1:0][1:0] wmem;
    xfer_t                  cur;
    logic [1:0]             lo_q;
    logic [PINS-1:0]        en;
    logic                   unused_wbits;

    assign unused_wbits = ^{cfg_wdata[31:WF_LSB+2], cfg_wdata[WF_LSB-1:0]};

    xs_cfg #(.NSPACE(NSPACE)) cfg_i (
        .clk(clk), .rst(rst), .strap_narrow(strap_narrow),
        .we(cfg_we), .sel(cfg_sel), .code(cfg_wdata[WF_LSB+1:WF_LSB]),
        .wmem(wmem)
    );

    xs_seq #(.NSPACE(NSPACE), .ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_space(req_space), .req_addr(req_addr),
        .req_size(req_size), .req_off(req_off), .req_write(req_write),
        .wmem(wmem), .busy(busy), .done(done), .cur(cur),
        .addr_q(ext_addr), .lo_q(lo_q)
    );

    assign en = lane_en(cur.w, cur.sb, lo_q);

    for (genvar s = 0; s < NSPACE; s++) begin : g_space
        xs_pinmux mux_i (
            .cfg_w(mwidth_e'(wmem[s])),
            .sel_here(busy && cur.space == 2'(s)),
            .en(en),
            .lo(lo_q),
            .pins_n(strb_n[s*PINS +: PINS])
        );
    end

    assign io_strb_n = !(busy && cur.space >= 2'(NSPACE));
    assign ext_wr    = cur.wr;

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NSPACE; i++)
            if (cfg_sel == SEL_W'(i)) cfg_rdata[WF_LSB +: 2] = wmem[i];
    end
endmodule

// File: rtl/xstrobe_gen_chk.sv
module xstrobe_gen_chk
    import xstrobe_pkg::*;
#(
    parameter int NSPACE = 2,
    parameter int ADDR_W = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    strap_narrow,
    input logic                    cfg_we,
    input logic [31:0]             cfg_wdata,
    input logic                    busy,
    input logic                    done,
    input logic [ADDR_W-1:0]       ext_addr,
    input logic                    ext_wr,
    input logic [NSPACE*PINS-1:0]  strb_n,
    input logic                    io_strb_n,
    input logic [1:0]              lo_q,
    input logic [NSPACE-1:0][1:0]  wmem
);
    logic [NSPACE-1:0] pin0_low;
    always_comb
        for (int i = 0; i < NSPACE; i++) pin0_low[i] = ~strb_n[i*PINS];

    a_r2_strap_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> wmem == {NSPACE{$past(strap_narrow) ? 2'b01 : 2'b11}});

    a_r3_reserved_kept: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[WF_LSB+1:WF_LSB] == 2'b10) |=> $stable(wmem));

    a_r7_addr_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(lo_q));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pin0_low == '0 && io_strb_n));

    a_r8_one_space: assert property (@(posedge clk) disable iff (rst)
        $countones({pin0_low, ~io_strb_n}) <= 1);

    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r10_hold_transfer: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(ext_addr) && $stable(ext_wr)));
endmodule

bind xstrobe_gen xstrobe_gen_chk #(.NSPACE(NSPACE), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .strap_narrow(strap_narrow),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .busy(busy), .done(done), .ext_addr(ext_addr), .ext_wr(ext_wr),
    .strb_n(strb_n), .io_strb_n(io_strb_n), .lo_q(lo_q), .wmem(wmem)
);

// File: tb/xstrobe_gen_tb_top.sv
module xstrobe_gen_tb_top;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strap_narrow = 1'b1;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_sel = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          req_valid = 1'b0;
    logic [1:0]    req_space = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [1:0]    req_off = '0;
    logic          req_write = 1'b0;
    logic          busy, done, ext_wr, io_strb_n;
    logic [AW-1:0] ext_addr;
    logic [7:0]    strb_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    logic [1:0] cw [2];
    int last_lo = 0;

    always #10 clk = ~clk;

    xstrobe_gen dut_i (
        .clk(clk), .rst(rst), .strap_narrow(strap_narrow),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_space(req_space), .req_addr(req_addr),
        .req_size(req_size), .req_off(req_off), .req_write(req_write),
        .busy(busy), .done(done), .ext_addr(ext_addr), .ext_wr(ext_wr),
        .strb_n(strb_n), .io_strb_n(io_strb_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic bit lane_on(int aw, int sb, int lo, int p);
        if (aw == 3) return (p >= lo) && (p < lo + sb);
        if (aw == 1) return (p < 2) && ((sb == 1) ? (p == (lo % 2)) : 1'b1);
        return p == 0;
    endfunction

    function automatic logic [7:0] exp_strb(int as, int aw, int sb, int lo, bit act);
        logic [7:0] r;
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++) begin
                if (p == 3 && cw[s] != 2'b11)      r[4*s+p] = lo[1];
                else if (p == 2 && cw[s] == 2'b00) r[4*s+p] = lo[0];
                else r[4*s+p] = !(act && as == s && lane_on(aw, sb, lo, p));
            end
        return r;
    endfunction

    function automatic string tag_of(int aw);
        return (aw == 3) ? "R4" : (aw == 1) ? "R5" : "R6";
    endfunction

    task automatic check_cfg(input string req);
        for (int s = 0; s < 2; s++) begin
            cfg_sel = s[0:0];
            #1;
            chk(req, $sformatf("rdata space %0d", s), cfg_rdata, {14'b0, cw[s], 16'b0});
        end
        chk("R7", "idle pins", {24'b0, strb_n}, {24'b0, exp_strb(0, 3, 1, last_lo, 0)});
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst = 1'b1;
        strap_narrow = strap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cw[0] = strap ? 2'b01 : 2'b11;
        cw[1] = cw[0];
        last_lo = 0;
        chk("R2", "busy after reset", {31'b0, busy}, 32'd0);
        chk("R2", "done after reset", {31'b0, done}, 32'd0);
        chk("R8", "io strobe after reset", {31'b0, io_strb_n}, 32'd1);
        check_cfg("R2");
    endtask

    task automatic wr_cfg(input int sel, input logic [1:0] code);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel[0:0];
        cfg_wdata = $urandom;
        cfg_wdata[17:16] = code;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (code != 2'b10) cw[sel] = code;
        check_cfg(code == 2'b10 ? "R3" : "R1");
    endtask

    task automatic do_req(input int space, input int size, input int off,
                          input logic [AW-1:0] addr, input bit wr, input bit pester);
        int sb, aw, wb, n, start, lo;
        sb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        aw = (space < 2) ? int'(cw[space]) : 3;
        wb = (aw == 0) ? 1 : (aw == 1) ? 2 : 4;
        n  = (sb > wb) ? sb / wb : 1;
        start = (sb == 4) ? 0 : (sb == 2) ? (off & 2) : off;
        @(negedge clk);
        req_valid = 1'b1;
        req_space = space[1:0];
        req_size  = size[1:0];
        req_off   = off[1:0];
        req_addr  = addr;
        req_write = wr;
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            lo = (start + k * wb) % 4;
            chk("R9", $sformatf("busy sub %0d", k), {31'b0, busy}, 32'd1);
            chk(space >= 2 ? "R7" : tag_of(aw), $sformatf("pins sub %0d", k),
                {24'b0, strb_n}, {24'b0, exp_strb(space, aw, sb, lo, 1)});
            chk("R8", "io strobe", {31'b0, io_strb_n}, {31'b0, !(space >= 2)});
            chk("R10", "word address", {8'b0, ext_addr}, {8'b0, addr});
            chk("R10", "direction", {31'b0, ext_wr}, {31'b0, wr});
            if (k == 0) begin
                req_valid = pester;
                req_addr  = ~addr;
                req_write = ~wr;
                req_space = 2'(space + 1);
                req_size  = 2'b10;
            end
            if (k < n - 1) @(posedge clk);
            last_lo = lo;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R9", "done pulse", {31'b0, done}, 32'd1);
        chk("R9", "busy at done", {31'b0, busy}, 32'd0);
        chk("R7", "pins at done", {24'b0, strb_n}, {24'b0, exp_strb(0, 3, 1, last_lo, 0)});
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "done one cycle", {31'b0, done}, 32'd0);
        chk("R10", "no restart", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset(1'b1);
        do_req(0, 2, 0, 24'h000123, 1'b0, 1'b0);   // R5 word split in two
        do_req(0, 0, 3, 24'h000456, 1'b1, 1'b0);   // R5 byte at offset 3
        do_req(2, 2, 0, 24'h000777, 1'b0, 1'b0);   // R7 I/O access
        wr_cfg(0, 2'b00);
        do_req(0, 2, 0, 24'h00ABCD, 1'b1, 1'b0);   // R6 four cycles
        do_req(0, 1, 2, 24'h00ABCE, 1'b0, 1'b0);   // R6 halfword in two
        do_req(1, 1, 3, 24'h001000, 1'b0, 1'b0);   // R5 halfword, other space 8-bit
        wr_cfg(1, 2'b11);
        do_req(1, 2, 0, 24'h002000, 1'b1, 1'b0);   // R4 word
        do_req(1, 0, 2, 24'h002001, 1'b0, 1'b0);   // R4 byte lane 2
        do_req(1, 1, 2, 24'h002002, 1'b0, 1'b0);   // R4 upper halfword
        wr_cfg(1, 2'b10);                          // R3 reserved
        wr_cfg(0, 2'b10);                          // R3 reserved
        do_req(0, 2, 0, 24'h0F0F0F, 1'b0, 1'b1);   // R10 request while busy
        do_reset(1'b0);
        do_req(0, 2, 0, 24'h003000, 1'b1, 1'b0);   // R4 after low strap
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(4) == 0)
                wr_cfg($urandom_range(1), 2'($urandom_range(3)));
            else
                do_req($urandom_range(3), $urandom_range(3), $urandom_range(3),
                       AW'($urandom), 1'($urandom), 1'($urandom));
        end
        summary();
    end
endmodule